// File: doc/BRIEF.md
# Shift and Rotate Flag Unit

This block executes the seven shift and rotate operations of a general-purpose integer pipeline on 8, 16, 32 or 64-bit operands and works out the carry, overflow, zero, sign and parity consequences of each. A copy of the carry, the extended carry, is produced alongside the ordinary carry so that a microcode sequencer can test it independently. The caller supplies the source, a count, a size select, the current flag vector and a mask that says which flags the operation may write. All flags outside the mask, and all flags when the masked count is zero, pass through from the incoming vector unchanged.

The result and the merged flag vector are computed combinationally and captured in one register stage. A two-state controller tracks whether the output register holds a fresh answer: it sits in `S_IDLE` until an operation is presented, then moves to `S_HOLD` (transition `T_LOAD`). It stays in `S_HOLD` while operations keep arriving (`T_RELOAD`) and returns to `S_IDLE` on the first cycle with no operation (`T_DRAIN`). `out_valid` is high exactly in `S_HOLD`.

Top module: `srf_unit`

## Requirements
- R1: The count is reduced to its low 6 bits when the size select is 3 (64-bit) and to its low 5 bits for every other size; only this masked count is used afterwards.
- R2: When the masked count is zero, or the operation code is 7 (pass), the result is the zero-extended source and every flag equals the incoming flag vector.
- R3: Flag bit positions are CF=0, ECF=1, OF=2, ZF=3, SF=4, PF=5; a flag whose mask bit is 0 is always copied from the incoming vector.
- R4: Operation 0 (shift left): result is the source shifted left and truncated; CF is source bit (W-count) when count ≤ W, else 0; OF is CF XOR result MSB.
- R5: Operation 1 (logical shift right): zeros enter at the top; CF is source bit (count-1) when count ≤ W, else 0; OF is the source MSB.
- R6: Operation 2 (arithmetic shift right): the sign bit fills from the top; CF is source bit (min(count,W)-1); OF is 0.
- R7: Operation 3 (rotate left) rotates by count mod W; CF is the result LSB and OF is result MSB XOR result LSB.
- R8: Operation 4 (rotate right) rotates by count mod W; CF is the result MSB and OF is result MSB XOR result bit W-2.
- R9: Operation 5 (rotate left through carry) rotates the W+1-bit field {CF, source} by count mod (W+1); the new CF is the bit that lands above the result, and OF is result MSB XOR new CF.
- R10: Operation 6 (rotate right through carry) rotates {CF, source} right by count mod (W+1); the new CF is the bit above the result and OF is old CF XOR source MSB.
- R11: ECF, when selected and the operation acts, takes the same value as the new CF.
- R12: When the operation acts, ZF is 1 for an all-zero result, SF is the result MSB, and PF is 1 when the low 8 result bits hold an even number of ones.
- R13: Size select 0, 1, 2, 3 gives W = 8, 16, 32, 64; only the low W source bits are used and the result is zero-extended to 64 bits.
- R14: Result and flags appear on the outputs one clock after an operation is presented with `in_valid`, with `out_valid` high; `out_valid` is low one clock after a cycle without `in_valid`, and low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 3 | Operation code (0..7) |
| in_size | input | 2 | Operand size select |
| in_src | input | 64 | Source operand |
| in_count | input | 8 | Shift or rotate count before masking |
| in_flags | input | 6 | Current flag vector |
| in_mask | input | 6 | Flags the operation may write |
| out_valid | output | 1 | Output register holds a fresh answer |
| out_result | output | 64 | Zero-extended result |
| out_flags | output | 6 | Merged flag vector |

## Verification
A wrong internal value here shows up on the very next output cycle, since there is no state beyond the single capture register: a bad masked count or modulo amount corrupts both the result and the carry of that one operation, while a wrong bit index in the carry or overflow logic leaves the result correct and flips only CF, ECF or OF. The bench therefore compares the full result and the full flag vector of every operation against a bit-by-bit model, with directed cases at counts of zero, one, W, W+1 and above, and random operations across all sizes and masks. A controller fault shows as `out_valid` disagreeing with the previous cycle's `in_valid`.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int XLEN  = 64;
    localparam int CNT_W = 8;
    localparam int NFLAG = 6;
    localparam int AMT_W = $clog2(XLEN + 2);
    localparam int ROT_W = 2 * XLEN + 2;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROL  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RCL  = 3'd5,
        OP_RCR  = 3'd6,
        OP_PASS = 3'd7
    } sr_op_e;

    localparam int FL_CF  = 0;
    localparam int FL_ECF = 1;
    localparam int FL_OF  = 2;
    localparam int FL_ZF  = 3;
    localparam int FL_SF  = 4;
    localparam int FL_PF  = 5;

    function automatic logic [XLEN-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(XLEN-8){1'b0}},  {8{1'b1}}};
            2'd1:    return {{(XLEN-16){1'b0}}, {16{1'b1}}};
            2'd2:    return {{(XLEN-32){1'b0}}, {32{1'b1}}};
            default: return {XLEN{1'b1}};
        endcase
    endfunction

    // Rotate the low n bits of x left by r (0 <= r <= n, x < 2**n).
    function automatic logic [XLEN:0] rotl_n(input logic [XLEN:0] x,
                                             input logic [AMT_W-1:0] r,
                                             input logic [AMT_W-1:0] n);
        logic [ROT_W-1:0] t;
        logic [ROT_W-1:0] m;
        t = ROT_W'(x);
        m = (ROT_W'(1) << n) - ROT_W'(1);
        t = ((t << r) | (t >> (n - r))) & m;
        return t[XLEN:0];
    endfunction
endpackage

// File: rtl/srf_count_norm.sv
module srf_count_norm
    import srf_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] count,
    output logic [AMT_W-1:0] wbits,
    output logic [5:0]       cnt,
    output logic [AMT_W-1:0] amt_w,
    output logic [AMT_W-1:0] amt_w1
);
    logic [AMT_W-1:0] cnt_x;

    always_comb begin
        cnt   = (size == 2'd3) ? count[5:0] : {1'b0, count[4:0]};
        cnt_x = AMT_W'(cnt);
        unique case (size)
            2'd0: begin
                wbits  = AMT_W'(8);
                amt_w  = AMT_W'(cnt[2:0]);
                amt_w1 = AMT_W'(cnt_x % AMT_W'(9));
            end
            2'd1: begin
                wbits  = AMT_W'(16);
                amt_w  = AMT_W'(cnt[3:0]);
                amt_w1 = AMT_W'(cnt_x % AMT_W'(17));
            end
            2'd2: begin
                wbits  = AMT_W'(32);
                amt_w  = AMT_W'(cnt[4:0]);
                amt_w1 = cnt_x;
            end
            default: begin
                wbits  = AMT_W'(64);
                amt_w  = cnt_x;
                amt_w1 = cnt_x;
            end
        endcase
    end
endmodule

// File: rtl/srf_shift_core.sv
module srf_shift_core
    import srf_pkg::*;
(
    input  sr_op_e           op,
    input  logic [1:0]       size,
    input  logic [XLEN-1:0]  src,
    input  logic [AMT_W-1:0] wbits,
    input  logic [5:0]       cnt,
    input  logic [AMT_W-1:0] amt_w,
    input  logic [AMT_W-1:0] amt_w1,
    input  logic             old_cf,
    output logic [XLEN-1:0]  res,
    output logic             cf,
    output logic             of,
    output logic             touch
);
    logic [XLEN-1:0]  wm;
    logic [XLEN-1:0]  xs;
    logic [XLEN-1:0]  sx;
    logic [XLEN:0]    ext;
    logic [XLEN:0]    rot;
    logic [5:0]       msb_i;
    logic [5:0]       sec_i;
    logic [AMT_W-1:0] cnt_x;
    logic [AMT_W-1:0] eff;
    logic             msb;

    always_comb begin
        wm    = width_mask(size);
        xs    = src & wm;
        msb_i = 6'(wbits - AMT_W'(1));
        sec_i = 6'(wbits - AMT_W'(2));
        msb   = xs[msb_i];
        cnt_x = AMT_W'(cnt);
        sx    = xs | (msb ? ~wm : '0);
        eff   = (cnt_x < wbits) ? cnt_x : wbits;
        ext   = {1'b0, xs} | ({{XLEN{1'b0}}, old_cf} << wbits);
        rot   = '0;
        res   = xs;
        cf    = old_cf;
        of    = 1'b0;
        touch = (cnt != 6'd0) && (op != OP_PASS);
        unique case (op)
            OP_SHL: begin
                res = (xs << cnt) & wm;
                cf  = (cnt_x <= wbits) ? xs[6'(wbits - cnt_x)] : 1'b0;
                of  = cf ^ res[msb_i];
            end
            OP_SHR: begin
                res = xs >> cnt;
                cf  = (cnt_x <= wbits) ? xs[6'(cnt_x - AMT_W'(1))] : 1'b0;
                of  = msb;
            end
            OP_SAR: begin
                res = XLEN'($signed(sx) >>> cnt) & wm;
                cf  = xs[6'(eff - AMT_W'(1))];
                of  = 1'b0;
            end
            OP_ROL: begin
                rot = rotl_n({1'b0, xs}, amt_w, wbits);
                res = rot[XLEN-1:0];
                cf  = res[0];
                of  = res[msb_i] ^ res[0];
            end
            OP_ROR: begin
                rot = rotl_n({1'b0, xs}, wbits - amt_w, wbits);
                res = rot[XLEN-1:0];
                cf  = res[msb_i];
                of  = res[msb_i] ^ res[sec_i];
            end
            OP_RCL: begin
                rot = rotl_n(ext, amt_w1, wbits + AMT_W'(1));
                res = rot[XLEN-1:0] & wm;
                cf  = rot[wbits];
                of  = res[msb_i] ^ rot[wbits];
            end
            OP_RCR: begin
                rot = rotl_n(ext, wbits + AMT_W'(1) - amt_w1, wbits + AMT_W'(1));
                res = rot[XLEN-1:0] & wm;
                cf  = rot[wbits];
                of  = old_cf ^ msb;
            end
            default: begin
                res = xs;
            end
        endcase
    end
endmodule

// File: rtl/srf_flag_merge.sv
module srf_flag_merge
    import srf_pkg::*;
(
    input  logic [XLEN-1:0]  res,
    input  logic [AMT_W-1:0] wbits,
    input  logic             cf,
    input  logic             of,
    input  logic             touch,
    input  logic [NFLAG-1:0] flags_in,
    input  logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] flags_out
);
    logic [NFLAG-1:0] fresh;

    always_comb begin
        fresh         = '0;
        fresh[FL_CF]  = cf;
        fresh[FL_ECF] = cf;
        fresh[FL_OF]  = of;
        fresh[FL_ZF]  = (res == '0);
        fresh[FL_SF]  = res[6'(wbits - AMT_W'(1))];
        fresh[FL_PF]  = ~^res[7:0];
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_sel
        assign flags_out[gi] = (touch && mask[gi]) ? fresh[gi] : flags_in[gi];
    end
endmodule

// File: rtl/srf_unit.sv
module srf_unit
    import srf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [1:0]       in_size,
    input  logic [XLEN-1:0]  in_src,
    input  logic [CNT_W-1:0] in_count,
    input  logic [NFLAG-1:0] in_flags,
    input  logic [NFLAG-1:0] in_mask,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic [NFLAG-1:0] out_flags
);
    typedef enum logic {S_IDLE, S_HOLD} st_e;

    st_e              state, state_nx;
    logic [AMT_W-1:0] wbits, amt_w, amt_w1;
    logic [5:0]       cnt;
    logic [XLEN-1:0]  core_res;
    logic             core_cf, core_of, core_touch;
    logic [NFLAG-1:0] merged;
    logic [1:0]       size_q;

    srf_count_norm u_norm (
        .size(in_size), .count(in_count), .wbits(wbits),
        .cnt(cnt), .amt_w(amt_w), .amt_w1(amt_w1)
    );

    srf_shift_core u_core (
        .op(sr_op_e'(in_op)), .size(in_size), .src(in_src), .wbits(wbits),
        .cnt(cnt), .amt_w(amt_w), .amt_w1(amt_w1), .old_cf(in_flags[FL_CF]),
        .res(core_res), .cf(core_cf), .of(core_of), .touch(core_touch)
    );

    srf_flag_merge u_merge (
        .res(core_res), .wbits(wbits), .cf(core_cf), .of(core_of),
        .touch(core_touch), .flags_in(in_flags), .mask(in_mask),
        .flags_out(merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nx = S_HOLD;       // T_LOAD
            S_HOLD:  if (!in_valid) state_nx = S_IDLE;      // T_DRAIN, else T_RELOAD
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_flags  <= '0;
            size_q     <= 2'd0;
        end else if (in_valid) begin
            out_result <= core_res;
            out_flags  <= merged;
            size_q     <= in_size;
        end
    end

    assign out_valid = (state == S_HOLD);

    a_r2_zero_count_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == 6'd0) |=> (out_flags == $past(in_flags)));

    a_r3_unselected_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_flags ^ $past(in_flags)) & ~$past(in_mask)) == '0));

    a_r11_ecf_follows_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && core_touch && in_mask[FL_CF] && in_mask[FL_ECF])
        |=> (out_flags[FL_CF] == out_flags[FL_ECF]));

    a_r13_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_result & ~width_mask(size_q)) == '0));

    a_r14_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r14_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/srf_unit_bench.sv
`timescale 1ns/1ps
module srf_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_src = '0;
    logic [7:0]  in_count = '0;
    logic [5:0]  in_flags = '0;
    logic [5:0]  in_mask = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    srf_unit u_srf_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_src(in_src), .in_count(in_count),
        .in_flags(in_flags), .in_mask(in_mask), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags)
    );

    // Bit-by-bit model: returns {flags[5:0], result[63:0]}
    function automatic logic [69:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [63:0] src, input logic [7:0] count,
                                          input logic [5:0] fl, input logic [5:0] mk);
        int w, c, r;
        logic [63:0] xs, res;
        logic [64:0] ex, rt;
        logic cf, of;
        logic [5:0] nf, outf;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : (sz == 2'd2) ? 32 : 64;
        c = (sz == 2'd3) ? int'(count[5:0]) : int'(count[4:0]);
        xs = '0;
        for (int i = 0; i < w; i++) xs[i] = src[i];
        if (c == 0 || op == 3'd7) return {fl, xs};
        res = '0; cf = 1'b0; of = 1'b0; ex = '0; rt = '0;
        for (int i = 0; i < w; i++) ex[i] = xs[i];
        ex[w] = fl[0];
        case (op)
            3'd0: begin
                for (int i = 0; i < w; i++) res[i] = (i >= c) ? xs[i-c] : 1'b0;
                cf = (c <= w) ? xs[w-c] : 1'b0;
                of = cf ^ res[w-1];
            end
            3'd1: begin
                for (int i = 0; i < w; i++) res[i] = (i + c < w) ? xs[i+c] : 1'b0;
                cf = (c <= w) ? xs[c-1] : 1'b0;
                of = xs[w-1];
            end
            3'd2: begin
                for (int i = 0; i < w; i++) res[i] = (i + c < w) ? xs[i+c] : xs[w-1];
                cf = xs[((c < w) ? c : w) - 1];
                of = 1'b0;
            end
            3'd3: begin
                r = c % w;
                for (int i = 0; i < w; i++) res[i] = xs[(i - r + w) % w];
                cf = res[0];
                of = res[w-1] ^ res[0];
            end
            3'd4: begin
                r = c % w;
                for (int i = 0; i < w; i++) res[i] = xs[(i + r) % w];
                cf = res[w-1];
                of = res[w-1] ^ res[w-2];
            end
            3'd5: begin
                r = c % (w + 1);
                for (int i = 0; i <= w; i++) rt[i] = ex[(i - r + w + 1) % (w + 1)];
                for (int i = 0; i < w; i++) res[i] = rt[i];
                cf = rt[w];
                of = res[w-1] ^ cf;
            end
            default: begin
                r = c % (w + 1);
                for (int i = 0; i <= w; i++) rt[i] = ex[(i + r) % (w + 1)];
                for (int i = 0; i < w; i++) res[i] = rt[i];
                cf = rt[w];
                of = fl[0] ^ xs[w-1];
            end
        endcase
        nf[0] = cf;
        nf[1] = cf;
        nf[2] = of;
        nf[3] = (res == 64'd0);
        nf[4] = res[w-1];
        nf[5] = ~^res[7:0];
        for (int i = 0; i < 6; i++) outf[i] = mk[i] ? nf[i] : fl[i];
        return {outf, res};
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [69:0] got, input logic [69:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual flags=%b result=%h expected flags=%b result=%h",
                     req, got[69:64], got[63:0], exp[69:64], exp[63:0]);
        end
    endtask

    // Drive one operation, sample the registered answer one clock later.
    task automatic run(input string req, input logic [2:0] op, input logic [1:0] sz,
                       input logic [63:0] src, input logic [7:0] cnt,
                       input logic [5:0] fl, input logic [5:0] mk);
        logic [69:0] exp;
        exp = model(op, sz, src, cnt, fl, mk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_src = src;
        in_count = cnt; in_flags = fl; in_mask = mk;
        @(negedge clk);
        check(req, {out_flags, out_result}, exp);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R14: actual out_valid=%b expected 1", out_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual run still active expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R14 reset state
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'd0 || out_flags !== 6'd0) begin
            errors++;
            $display("FAIL R14: actual valid=%b result=%h flags=%b expected 0/0/0",
                     out_valid, out_result, out_flags);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: 32-bit count 33 masks to 1; 64-bit count 65 masks to 1; 8-bit count 40 masks to 8
        run("R1", 3'd0, 2'd2, 64'h8000_0001, 8'd33, 6'b000000, 6'b111111);
        run("R1", 3'd1, 2'd3, 64'hF000_0000_0000_0003, 8'd65, 6'b000000, 6'b111111);
        run("R1", 3'd0, 2'd0, 64'h0000_0000_0000_0081, 8'd40, 6'b000000, 6'b111111);
        // R2: masked count zero, and pass op
        run("R2", 3'd5, 2'd2, 64'hFFFF_FFFF_1234_5678, 8'd32, 6'b101010, 6'b111111);
        run("R2", 3'd7, 2'd3, 64'hDEAD_BEEF_0000_0001, 8'd5, 6'b010101, 6'b111111);
        // R3: only masked flags change
        run("R3", 3'd0, 2'd0, 64'h80, 8'd1, 6'b111010, 6'b000101);
        // R4..R10 directed boundaries
        run("R4", 3'd0, 2'd0, 64'h40, 8'd1, 6'd0, 6'b111111);
        run("R4", 3'd0, 2'd1, 64'h0001, 8'd16, 6'd0, 6'b111111);
        run("R4", 3'd0, 2'd1, 64'hFFFF, 8'd17, 6'd0, 6'b111111);
        run("R5", 3'd1, 2'd0, 64'h81, 8'd8, 6'd0, 6'b111111);
        run("R6", 3'd2, 2'd0, 64'h80, 8'd20, 6'd0, 6'b111111);
        run("R6", 3'd2, 2'd2, 64'h8000_0003, 8'd2, 6'b000100, 6'b111111);
        run("R7", 3'd3, 2'd0, 64'h81, 8'd9, 6'd0, 6'b111111);
        run("R8", 3'd4, 2'd1, 64'h0001, 8'd1, 6'd0, 6'b111111);
        run("R9", 3'd5, 2'd0, 64'h80, 8'd9, 6'b000001, 6'b111111);
        run("R9", 3'd5, 2'd0, 64'h80, 8'd1, 6'b000000, 6'b111111);
        run("R10", 3'd6, 2'd1, 64'h0001, 8'd17, 6'b000001, 6'b111111);
        run("R10", 3'd6, 2'd3, 64'h1, 8'd1, 6'b000001, 6'b111111);
        // R11: ECF with CF; R12: zero result; R13: upper source bits ignored
        run("R11", 3'd1, 2'd2, 64'h1, 8'd1, 6'b000000, 6'b000011);
        run("R12", 3'd1, 2'd0, 64'h01, 8'd1, 6'd0, 6'b111111);
        run("R13", 3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FF01, 8'd4, 6'd0, 6'b111111);

        // Random operations across all sizes, masks and counts
        for (int k = 0; k < 600; k++) begin
            logic [2:0] op;
            logic [1:0] sz;
            logic [7:0] cn;
            op = 3'($urandom_range(0, 7));
            sz = 2'($urandom_range(0, 3));
            cn = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 255))
                                              : 8'($urandom_range(0, 10));
            run(op_req(op), op, sz, {$urandom, $urandom}, cn,
                6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)));
        end

        // R14: idle cycle drops out_valid
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R14: actual out_valid=%b expected 0", out_valid);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule